// File: doc/BRIEF.md
# Ring-Rotated Multi-Channel Convolution Array

This block computes one layer slice of a convolution across many input channels using a closed ring of identical engines. Each engine owns one output channel. It holds one input-channel tile, which is a 3x3 window of signed pixels. On every rotation step each engine hands its tile to the next engine downstream and takes the tile from the engine upstream. It then multiplies the tile it just held, tap by tap, with the 3x3 kernel that matches that tile's channel, and adds the result into its accumulator. After as many steps as there are engines, every engine has met every tile of the current input group once.

A central sequencer runs the whole pass. On `start` it clears all accumulators. For each input group it pulls the group's tiles from an external tile source, one engine per cycle, and then performs the rotation steps. After the last group it drains the accumulators on the output port, one engine per cycle. Kernels are written beforehand into each engine's local store. They are laid out cyclically, so that the slot read at a given step always holds the weight for the tile that has arrived at that step.

Top module: `ring_conv_array`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `done`, `out_valid` and `ld_req` are all low.
- R2: `start` in a cycle where `busy` is low begins a pass, and `busy` is high from the next cycle on. `start` while `busy` is high has no effect on the drained values, the number of drained values or the pass length.
- R3: For a pass of G groups, the block raises `ld_req` for G*NE cycles in total. `ld_chan` counts 0, 1, ... G*NE-1 across those cycles, and channel g*NE+e is captured into engine e from `ld_tile` in the same cycle it is requested. Tap k of a tile sits at bits [k*DW +: DW].
- R4: On each rotation step, engine e takes its new tile from engine (e-1) mod NE, so engine 0 is fed by engine NE-1. At step s of group g, engine e therefore works on channel g*NE + ((e-s) mod NE).
- R5: Kernel slot g*NE+s of engine e must hold the kernel for output e and input channel g*NE + ((e-s) mod NE). It is written through `cw_en`/`cw_engine`/`cw_slot`/`cw_data` while `busy` is low, with tap k at bits [k*CW +: CW].
- R6: The value drained for engine e equals the sum, over all channels c < G*NE and taps k, of tile[c][k]*kernel[e][c][k]. All values are two's-complement signed, and the sum wraps at AW bits.
- R7: Accumulators are cleared when a pass starts, so nothing from an earlier pass carries over.
- R8: After the last group, `out_valid` is high for exactly NE consecutive cycles, with `out_engine` counting 0 to NE-1.
- R9: `done` is high for exactly one cycle, in the cycle after the last drained value, and `busy` is low in that cycle.
- R10: A pass with G groups keeps `busy` high for exactly G*2*NE + NE cycles. `n_groups` is sampled at start and must lie in 1..MAX_GROUPS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a pass when idle |
| n_groups | input | $clog2(MAX_GROUPS+1) | Number of input groups for the pass |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle pulse after the drain |
| ld_req | output | 1 | Tile request, data taken in the same cycle |
| ld_chan | output | $clog2(MAX_GROUPS*NE) | Input channel being requested |
| ld_tile | input | 9*DW | Requested tile, 9 signed taps |
| cw_en | input | 1 | Kernel write strobe |
| cw_engine | input | $clog2(NE) | Engine addressed by the kernel write |
| cw_slot | input | $clog2(MAX_GROUPS*NE) | Kernel slot within that engine |
| cw_data | input | 9*CW | Kernel, 9 signed taps |
| out_valid | output | 1 | Drained accumulator on `out_data` |
| out_engine | output | $clog2(NE) | Engine whose sum is on `out_data` |
| out_data | output | AW | Signed accumulated sum |

## Verification
The checker takes for granted that kernel writes arrive only while the array is idle. It also assumes that `n_groups` lies between one and MAX_GROUPS whenever a pass is started. Both are written as properties over the ports. The bench keeps to them: it loads every kernel slot before the first start and only picks group counts of one or two with MAX_GROUPS of two. The bench acts as a combinational tile memory keyed by `ld_chan`, which matches the same-cycle capture the requests assume. A stray `start` during a pass stays within the contract and is used on purpose.

// File: rtl/ring_conv_pkg.sv
package ring_conv_pkg;

   localparam int TAPS = 9;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_LOAD,
      ST_ROT,
      ST_DRAIN
   } ring_state_e;

endpackage

// File: rtl/ring_conv_mac.sv
module ring_conv_mac
   import ring_conv_pkg::*;
#(
   parameter int DW = 8,
   parameter int CW = 8,
   parameter int AW = 32
) (
   input  logic [TAPS*DW-1:0]   win,
   input  logic [TAPS*CW-1:0]   kern,
   output logic signed [AW-1:0] dot
);

   localparam int PW = DW + CW;

   logic signed [AW-1:0] ext [TAPS];

   for (genvar k = 0; k < TAPS; k++) begin : g_tap
      logic signed [DW-1:0] px;
      logic signed [CW-1:0] wt;
      logic signed [PW-1:0] prod;
      assign px     = win[k*DW +: DW];
      assign wt     = kern[k*CW +: CW];
      assign prod   = PW'(px) * PW'(wt);
      assign ext[k] = AW'(prod);
   end

   always_comb begin
      dot = '0;
      for (int k = 0; k < TAPS; k++) begin
         dot = dot + ext[k];
      end
   end

endmodule

// File: rtl/ring_conv_engine.sv
module ring_conv_engine
   import ring_conv_pkg::*;
#(
   parameter int DW    = 8,
   parameter int CW    = 8,
   parameter int AW    = 32,
   parameter int NSLOT = 64,
   parameter int SW    = 6
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  acc_clr,
   input  logic                  ld_en,
   input  logic [TAPS*DW-1:0]    ld_tile,
   input  logic                  rot,
   input  logic [SW-1:0]         slot,
   input  logic [TAPS*DW-1:0]    up_tile,
   input  logic                  cw_we,
   input  logic [SW-1:0]         cw_slot,
   input  logic [TAPS*CW-1:0]    cw_data,
   output logic [TAPS*DW-1:0]    tile_q,
   output logic signed [AW-1:0]  acc_q
);

   logic [TAPS*CW-1:0]   kern_mem [NSLOT];
   logic [TAPS*CW-1:0]   cur_kern;
   logic signed [AW-1:0] dot;

   always_ff @(posedge clk) begin
      if (cw_we) begin
         kern_mem[cw_slot] <= cw_data;
      end
   end

   assign cur_kern = kern_mem[slot];

   ring_conv_mac #(.DW(DW), .CW(CW), .AW(AW)) mac_i (
      .win  (tile_q),
      .kern (cur_kern),
      .dot  (dot)
   );

   // Tile register: loaded from the source, or handed on around the ring.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tile_q <= '0;
      end else if (ld_en) begin
         tile_q <= ld_tile;
      end else if (rot) begin
         tile_q <= up_tile;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || acc_clr) begin
         acc_q <= '0;
      end else if (rot) begin
         acc_q <= acc_q + dot;
      end
   end

endmodule

// File: rtl/ring_conv_ctrl.sv
module ring_conv_ctrl
   import ring_conv_pkg::*;
#(
   parameter int NE         = 16,
   parameter int MAX_GROUPS = 4,
   parameter int EW         = 4,
   parameter int GBW        = 2,
   parameter int NGW        = 3,
   parameter int SW         = 6
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [NGW-1:0] n_groups,
   output logic           busy,
   output logic           done,
   output logic           acc_clr,
   output logic           ld_req,
   output logic [NE-1:0]  ld_en,
   output logic           rot,
   output logic [SW-1:0]  slot,
   output logic           drain,
   output logic [EW-1:0]  idx
);

   ring_state_e    st_q;
   logic [EW-1:0]  cnt_q;
   logic [GBW-1:0] grp_q;
   logic [NGW-1:0] ngrp_q;
   logic           cnt_last;
   logic           grp_last;

   assign cnt_last = (cnt_q == EW'(NE - 1));
   assign grp_last = ((NGW'(grp_q) + NGW'(1)) == ngrp_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         cnt_q  <= '0;
         grp_q  <= '0;
         ngrp_q <= '0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (start) begin
                  st_q   <= ST_LOAD;
                  cnt_q  <= '0;
                  grp_q  <= '0;
                  ngrp_q <= n_groups;
               end
            end
            ST_LOAD: begin
               cnt_q <= cnt_last ? '0 : cnt_q + EW'(1);
               if (cnt_last) begin
                  st_q <= ST_ROT;
               end
            end
            ST_ROT: begin
               cnt_q <= cnt_last ? '0 : cnt_q + EW'(1);
               if (cnt_last) begin
                  if (grp_last) begin
                     st_q <= ST_DRAIN;
                  end else begin
                     st_q  <= ST_LOAD;
                     grp_q <= grp_q + GBW'(1);
                  end
               end
            end
            ST_DRAIN: begin
               cnt_q <= cnt_last ? '0 : cnt_q + EW'(1);
               if (cnt_last) begin
                  st_q <= ST_IDLE;
                  done <= 1'b1;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign busy    = (st_q != ST_IDLE);
   assign acc_clr = (st_q == ST_IDLE) && start;
   assign ld_req  = (st_q == ST_LOAD);
   assign rot     = (st_q == ST_ROT);
   assign drain   = (st_q == ST_DRAIN);
   assign idx     = cnt_q;
   // Channel during loading and kernel slot during rotation share one formula.
   assign slot    = SW'(SW'(grp_q) * SW'(NE) + SW'(cnt_q));

   for (genvar e = 0; e < NE; e++) begin : g_ld
      assign ld_en[e] = ld_req && (cnt_q == EW'(e));
   end

endmodule

// File: rtl/ring_conv_array.sv
module ring_conv_array
   import ring_conv_pkg::*;
#(
   parameter int NE         = 16,
   parameter int MAX_GROUPS = 4,
   parameter int DW         = 8,
   parameter int CW         = 8,
   parameter int AW         = 32,
   localparam int NSLOT     = MAX_GROUPS * NE,
   localparam int SW        = $clog2(NSLOT),
   localparam int EW        = $clog2(NE),
   localparam int NGW       = $clog2(MAX_GROUPS + 1),
   localparam int GBW       = (MAX_GROUPS > 1) ? $clog2(MAX_GROUPS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [NGW-1:0]       n_groups,
   output logic                 busy,
   output logic                 done,
   output logic                 ld_req,
   output logic [SW-1:0]        ld_chan,
   input  logic [TAPS*DW-1:0]   ld_tile,
   input  logic                 cw_en,
   input  logic [EW-1:0]        cw_engine,
   input  logic [SW-1:0]        cw_slot,
   input  logic [TAPS*CW-1:0]   cw_data,
   output logic                 out_valid,
   output logic [EW-1:0]        out_engine,
   output logic signed [AW-1:0] out_data
);

   if (NE < 2) begin : g_bad_ne
      $error("ring_conv_array: NE must be at least 2");
   end
   if (MAX_GROUPS < 1) begin : g_bad_grp
      $error("ring_conv_array: MAX_GROUPS must be at least 1");
   end
   if (AW < DW + CW + 4) begin : g_bad_aw
      $error("ring_conv_array: AW too narrow for a 9-tap sum");
   end

   logic                 acc_clr;
   logic [NE-1:0]        ld_en;
   logic                 rot;
   logic [SW-1:0]        slot;
   logic [EW-1:0]        idx;
   logic [TAPS*DW-1:0]   tile_all [NE];
   logic signed [AW-1:0] acc_all  [NE];

   ring_conv_ctrl #(
      .NE(NE), .MAX_GROUPS(MAX_GROUPS), .EW(EW), .GBW(GBW), .NGW(NGW), .SW(SW)
   ) ctrl_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .n_groups (n_groups),
      .busy     (busy),
      .done     (done),
      .acc_clr  (acc_clr),
      .ld_req   (ld_req),
      .ld_en    (ld_en),
      .rot      (rot),
      .slot     (slot),
      .drain    (out_valid),
      .idx      (idx)
   );

   for (genvar e = 0; e < NE; e++) begin : g_eng
      ring_conv_engine #(
         .DW(DW), .CW(CW), .AW(AW), .NSLOT(NSLOT), .SW(SW)
      ) eng_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .acc_clr (acc_clr),
         .ld_en   (ld_en[e]),
         .ld_tile (ld_tile),
         .rot     (rot),
         .slot    (slot),
         .up_tile (tile_all[(e + NE - 1) % NE]),
         .cw_we   (cw_en && (cw_engine == EW'(e))),
         .cw_slot (cw_slot),
         .cw_data (cw_data),
         .tile_q  (tile_all[e]),
         .acc_q   (acc_all[e])
      );
   end

   assign ld_chan    = slot;
   assign out_engine = idx;
   assign out_data   = acc_all[idx];

endmodule

// File: rtl/ring_conv_array_chk.sv
module ring_conv_array_chk #(
   parameter int NE         = 16,
   parameter int MAX_GROUPS = 4,
   localparam int SW        = $clog2(MAX_GROUPS * NE),
   localparam int EW        = $clog2(NE),
   localparam int NGW       = $clog2(MAX_GROUPS + 1)
) (
   input logic           clk,
   input logic           rst_n,
   input logic           start,
   input logic [NGW-1:0] n_groups,
   input logic           busy,
   input logic           done,
   input logic           ld_req,
   input logic [SW-1:0]  ld_chan,
   input logic [NE-1:0]  ld_en,
   input logic           cw_en,
   input logic           out_valid,
   input logic [EW-1:0]  out_engine
);

   assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   assert_ld_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_req && $past(ld_req)) |-> (ld_chan == SW'($past(ld_chan) + 1'b1)));

   assert_ld_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ld_en) && (ld_req || (ld_en == '0)));

   assert_cw_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cw_en |-> !busy);

   assert_drain_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> (out_engine == '0));

   assert_drain_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(out_valid)) |-> (out_engine == EW'($past(out_engine) + 1'b1)));

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(out_valid)));

   assert_groups_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |-> (n_groups >= NGW'(1) && n_groups <= NGW'(MAX_GROUPS)));

endmodule

bind ring_conv_array ring_conv_array_chk #(
   .NE(NE), .MAX_GROUPS(MAX_GROUPS)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .n_groups   (n_groups),
   .busy       (busy),
   .done       (done),
   .ld_req     (ld_req),
   .ld_chan    (ld_chan),
   .ld_en      (ld_en),
   .cw_en      (cw_en),
   .out_valid  (out_valid),
   .out_engine (out_engine)
);

// File: tb/ring_conv_array_tb_top.sv
module ring_conv_array_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NE  = 4;
   localparam int MG  = 2;
   localparam int DW  = 8;
   localparam int CW  = 8;
   localparam int AW  = 24;
   localparam int NCH = NE * MG;
   localparam int SW  = $clog2(NCH);
   localparam int EW  = $clog2(NE);
   localparam int NGW = $clog2(MG + 1);

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 start = 1'b0;
   logic [NGW-1:0]       n_groups = '0;
   logic                 busy, done, ld_req, out_valid;
   logic [SW-1:0]        ld_chan;
   logic [9*DW-1:0]      ld_tile;
   logic                 cw_en = 1'b0;
   logic [EW-1:0]        cw_engine = '0;
   logic [SW-1:0]        cw_slot = '0;
   logic [9*CW-1:0]      cw_data = '0;
   logic [EW-1:0]        out_engine;
   logic signed [AW-1:0] out_data;

   int tile_v [NCH][9];
   int wt_v   [NE][NCH][9];
   logic [9*DW-1:0] tile_mem [NCH];

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   int ld_idx = 0;
   logic signed [AW-1:0] exp_q [$];
   int                   eng_q [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   ring_conv_array #(.NE(NE), .MAX_GROUPS(MG), .DW(DW), .CW(CW), .AW(AW)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .n_groups(n_groups),
      .busy(busy), .done(done), .ld_req(ld_req), .ld_chan(ld_chan),
      .ld_tile(ld_tile), .cw_en(cw_en), .cw_engine(cw_engine),
      .cw_slot(cw_slot), .cw_data(cw_data), .out_valid(out_valid),
      .out_engine(out_engine), .out_data(out_data)
   );

   // Tile source answers in the same cycle (R3).
   assign ld_tile = tile_mem[ld_chan];

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   // Monitor: load order (R3) and drained results (R4 R5 R6 R8).
   always @(negedge clk) begin
      if (rst_n && ld_req) begin
         chk(ld_chan == SW'(ld_idx), "R3", "requested channel", ld_chan, ld_idx);
         ld_idx++;
      end
      if (rst_n && out_valid) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R8", "unexpected drain beat", out_engine, -1);
         end else begin
            logic signed [AW-1:0] ev;
            int ee;
            ev = exp_q.pop_front();
            ee = eng_q.pop_front();
            chk(out_engine == EW'(ee), "R8", "drain engine order", out_engine, ee);
            chk(out_data == ev, "R4 R5 R6", "engine sum", out_data, ev);
         end
      end
   end

   function automatic int tv(int seed, int a, int b, int c);
      return ((a * 37 + b * 11 + c * 5 + seed * 53) % 256) - 128;
   endfunction

   task automatic fill(input int seed, input int mode);
      for (int c = 0; c < NCH; c++) begin
         for (int k = 0; k < 9; k++) begin
            tile_v[c][k] = (mode == 1) ? -128 : tv(seed, c, k, 0);
            tile_mem[c][k*DW +: DW] = DW'(tile_v[c][k]);
         end
      end
      for (int e = 0; e < NE; e++) begin
         for (int c = 0; c < NCH; c++) begin
            for (int k = 0; k < 9; k++) begin
               wt_v[e][c][k] = (mode == 1) ? -128 : tv(seed + 7, e, c, k);
            end
         end
      end
   endtask

   // Cyclic kernel layout (R5): slot g*NE+s of engine e holds channel g*NE+((e-s) mod NE).
   task automatic load_kernels();
      for (int e = 0; e < NE; e++) begin
         for (int g = 0; g < MG; g++) begin
            for (int s = 0; s < NE; s++) begin
               int c;
               c = g * NE + ((e - s + NE) % NE);
               @(negedge clk);
               cw_en     = 1'b1;
               cw_engine = EW'(e);
               cw_slot   = SW'(g * NE + s);
               for (int k = 0; k < 9; k++) cw_data[k*CW +: CW] = CW'(wt_v[e][c][k]);
            end
         end
      end
      @(negedge clk);
      cw_en = 1'b0;
   endtask

   task automatic run_pass(input int ng, input bit stray_start);
      int busy_cnt;
      for (int e = 0; e < NE; e++) begin
         longint sum;
         sum = 0;
         for (int c = 0; c < ng * NE; c++) begin
            for (int k = 0; k < 9; k++) sum += longint'(tile_v[c][k]) * wt_v[e][c][k];
         end
         exp_q.push_back(AW'(sum));
         eng_q.push_back(e);
      end
      ld_idx = 0;
      @(negedge clk);
      start    = 1'b1;
      n_groups = NGW'(ng);
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R2", "busy after start", busy, 1);
      busy_cnt = 1;
      while (!done) begin
         @(negedge clk);
         if (busy) busy_cnt++;
         // Stray start mid-pass with a different group count (R2).
         if (stray_start && busy_cnt == 6) begin
            start    = 1'b1;
            n_groups = NGW'(3 - ng);
         end else begin
            start = 1'b0;
         end
      end
      chk(busy == 1'b0, "R9", "busy low with done", busy, 0);
      chk(busy_cnt == ng * 2 * NE + NE, "R10", "busy cycles", busy_cnt, ng * 2 * NE + NE);
      @(negedge clk);
      chk(done == 1'b0, "R9", "done one cycle only", done, 0);
      chk(exp_q.size() == 0, "R8", "drain beats missing", exp_q.size(), 0);
      chk(ld_idx == ng * NE, "R3", "tile requests", ld_idx, ng * NE);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(busy == 1'b0 && done == 1'b0, "R1", "busy/done in reset", {busy, done}, 0);
      chk(out_valid == 1'b0 && ld_req == 1'b0, "R1", "valid/req in reset", {out_valid, ld_req}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 1'b0 && out_valid == 1'b0, "R1", "idle after reset", {busy, out_valid}, 0);

      fill(1, 0);
      load_kernels();
      run_pass(2, 1'b0);
      // Fewer groups after a larger pass: stale sums must be gone (R7).
      run_pass(1, 1'b0);
      fill(4, 0);
      load_kernels();
      run_pass(2, 1'b1);
      run_pass(1, 1'b1);
      // Extreme magnitudes to probe signed products (R6).
      fill(0, 1);
      load_kernels();
      run_pass(2, 1'b0);

      repeat (3) @(negedge clk);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule